// File: doc/BRIEF.md
# Fixed-Priority Trap Controller

This block gathers error reports from a set of fault detectors and latches each one in a sticky pending flag. Every flag is tied to one fixed trap level in the band 8 to 15, above every maskable interrupt level. The arithmetic error sits at level 11, address errors at 12, stack errors at 13 and oscillator failure at 14. The remaining levels are free for other detectors. From the pending set the block picks the highest level. It raises a request to the processor core, carrying a 3-bit vector index, the new priority level and a soft/hard class flag.

The block holds the CPU priority level itself. A request goes out only when the chosen trap outranks that level. When the core acknowledges, the trap level is loaded as the new CPU level. Traps therefore nest: a higher trap can interrupt the handler of a lower one. Level 7 masks every interrupt but never a trap. Software lowers the level again through a write port, for example on return from a handler. Pending flags stay set until software clears them, so a handler can see every trap that was raised together with its own.

Top module: `trap_ctrl`

## Requirements
- R1: After reset all pending flags are 0, the CPU level is 0 and no trap is requested.
- R2: A fault pulse on bit i sets pending bit i one clock later. The bit then stays set for as long as no clear strobe hits it.
- R3: A clear strobe on bit i clears pending bit i on the next clock. If a fault and a clear arrive on the same bit in the same cycle, the bit stays set.
- R4: Pending bit i stands for trap level 8+i. The highest set bit is selected. The vector output is i and the level output is 8+i, so level bit 3 is always 1 while a trap is offered.
- R5: A request is raised only while the selected level is strictly greater than the CPU level. With the CPU level at 7 a pending trap is still requested, and at an equal level it is not.
- R6: An acknowledge while a request is raised loads the CPU level with the offered level on the next clock. An acknowledge without a request leaves the CPU level unchanged.
- R7: Nesting: after a trap is taken, a newly pending higher-level trap raises a request again, while a lower-level trap stays pending without a request.
- R8: The class output is 1 (hard) for levels 12 to 15 and 0 (soft) for levels 8 to 11.
- R9: A software level write loads the CPU level on the next clock. An acknowledge that takes a trap in the same cycle has precedence over the write.
- R10: Faults raised on several bits in the same cycle all become pending together, and only the highest of them is offered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fault_i | input | 8 | One-cycle fault pulses, bit i for level 8+i |
| clr_i | input | 8 | Software clear strobes for the pending flags |
| ack_i | input | 1 | Core accepts the offered trap |
| lvl_we_i | input | 1 | Software write strobe for the CPU level |
| lvl_wdata_i | input | 4 | CPU level value to write |
| trap_req_o | output | 1 | Trap request to the core |
| trap_vec_o | output | 3 | Vector index of the offered trap |
| trap_lvl_o | output | 4 | Priority level of the offered trap |
| trap_hard_o | output | 1 | Class of the offered trap, 1 for hard |
| pending_o | output | 8 | Sticky pending flags |
| cpu_lvl_o | output | 4 | Current CPU priority level |

## Verification
The assertions assume that the level write port carries a value below the trap band or a legal trap level. They assume that acknowledges come only in response to a raised request. Stray acknowledges are harmless, but the nesting properties read the level as set by an acknowledge. The bench drives fault, clear and acknowledge on the falling edge and holds each strobe for exactly one cycle. It writes the level only with 0, 7 and 8, and it issues one deliberate acknowledge without a request to check that it is ignored.

// File: rtl/trap_pkg.sv
// Package: shared constants and types for the trap controller.
// Assumes trap levels form one contiguous band starting at TRAP_BASE.
package trap_pkg;
    localparam int TRAP_BASE = 8;

    typedef enum logic {
        TRAP_SOFT = 1'b0,
        TRAP_HARD = 1'b1
    } trap_class_e;
endpackage

// File: rtl/trap_pend_bank.sv
// Module: bank of sticky pending flags, one per trap source.
// Assumes fault and clear are single-cycle strobes; a fault wins over a
// clear in the same cycle so that no fault is ever lost.
module trap_pend_bank #(
    parameter int N_TRAPS = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_TRAPS-1:0] set_i,
    input  logic [N_TRAPS-1:0] clr_i,
    output logic [N_TRAPS-1:0] pend_o
);
    for (genvar g = 0; g < N_TRAPS; g++) begin : g_flag
        logic flag_q;

        // Hold one flag: set by its fault, cleared by its strobe.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flag_q <= 1'b0;
            end else if (set_i[g]) begin
                flag_q <= 1'b1;
            end else if (clr_i[g]) begin
                flag_q <= 1'b0;
            end
        end

        assign pend_o[g] = flag_q;
    end
endmodule

// File: rtl/trap_prio_enc.sv
// Module: fixed-priority selector, the highest set bit wins.
// Assumes nothing about how many bits are set; valid is 0 when none are.
module trap_prio_enc #(
    parameter int N_TRAPS = 8,
    localparam int IDX_W = $clog2(N_TRAPS)
) (
    input  logic [N_TRAPS-1:0] pend_i,
    output logic               valid_o,
    output logic [IDX_W-1:0]   idx_o
);
    // Scan upward so that later (higher) bits override lower ones.
    always_comb begin
        valid_o = 1'b0;
        idx_o   = '0;
        for (int i = 0; i < N_TRAPS; i++) begin
            if (pend_i[i]) begin
                valid_o = 1'b1;
                idx_o   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/trap_level_reg.sv
// Module: CPU priority level register.
// Assumes an acknowledge that takes a trap outranks a software write.
module trap_level_reg #(
    parameter int LVL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take_i,
    input  logic [LVL_W-1:0] take_lvl_i,
    input  logic             we_i,
    input  logic [LVL_W-1:0] wdata_i,
    output logic [LVL_W-1:0] lvl_o
);
    logic [LVL_W-1:0] lvl_q;

    // Load the trap level on a take, otherwise the written value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q <= '0;
        end else if (take_i) begin
            lvl_q <= take_lvl_i;
        end else if (we_i) begin
            lvl_q <= wdata_i;
        end
    end

    assign lvl_o = lvl_q;
endmodule

// File: rtl/trap_ctrl.sv
// Module: top of the fixed-priority trap controller.
// Latches fault pulses, offers the highest pending trap when it outranks
// the CPU level, and raises the level on acknowledge. Assumes the upper
// half of the trap band is the hard class.
module trap_ctrl #(
    parameter int N_TRAPS = 8,
    parameter int LVL_W   = 4,
    localparam int IDX_W  = $clog2(N_TRAPS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_TRAPS-1:0] fault_i,
    input  logic [N_TRAPS-1:0] clr_i,
    input  logic               ack_i,
    input  logic               lvl_we_i,
    input  logic [LVL_W-1:0]   lvl_wdata_i,
    output logic               trap_req_o,
    output logic [IDX_W-1:0]   trap_vec_o,
    output logic [LVL_W-1:0]   trap_lvl_o,
    output logic               trap_hard_o,
    output logic [N_TRAPS-1:0] pending_o,
    output logic [LVL_W-1:0]   cpu_lvl_o
);
    import trap_pkg::*;

    logic [N_TRAPS-1:0] pend;
    logic               sel_valid;
    logic [IDX_W-1:0]   sel_idx;
    logic [LVL_W-1:0]   sel_lvl;
    logic [LVL_W-1:0]   cpu_lvl;
    logic               take;
    trap_class_e        sel_class;

    trap_pend_bank #(.N_TRAPS(N_TRAPS)) u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (fault_i),
        .clr_i  (clr_i),
        .pend_o (pend)
    );

    trap_prio_enc #(.N_TRAPS(N_TRAPS)) u_enc (
        .pend_i  (pend),
        .valid_o (sel_valid),
        .idx_o   (sel_idx)
    );

    // Map the winning index to its level and class.
    always_comb begin
        sel_lvl   = LVL_W'(TRAP_BASE) + LVL_W'(sel_idx);
        sel_class = sel_idx[IDX_W-1] ? TRAP_HARD : TRAP_SOFT;
    end

    assign trap_req_o = sel_valid && (sel_lvl > cpu_lvl);
    assign take       = ack_i && trap_req_o;

    trap_level_reg #(.LVL_W(LVL_W)) u_lvl (
        .clk        (clk),
        .rst_n      (rst_n),
        .take_i     (take),
        .take_lvl_i (sel_lvl),
        .we_i       (lvl_we_i),
        .wdata_i    (lvl_wdata_i),
        .lvl_o      (cpu_lvl)
    );

    assign trap_vec_o  = sel_idx;
    assign trap_lvl_o  = sel_lvl;
    assign trap_hard_o = (sel_class == TRAP_HARD);
    assign pending_o   = pend;
    assign cpu_lvl_o   = cpu_lvl;
endmodule

// File: rtl/trap_ctrl_chk.sv
// Module: property checker bound to trap_ctrl; observes ports only.
// Assumes acknowledges follow requests and level writes stay legal.
module trap_ctrl_chk #(
    parameter int N_TRAPS = 8,
    parameter int LVL_W   = 4,
    localparam int IDX_W  = $clog2(N_TRAPS)
) (
    input logic               clk,
    input logic               rst_n,
    input logic [N_TRAPS-1:0] fault_i,
    input logic [N_TRAPS-1:0] clr_i,
    input logic               ack_i,
    input logic               trap_req_o,
    input logic [IDX_W-1:0]   trap_vec_o,
    input logic [LVL_W-1:0]   trap_lvl_o,
    input logic               trap_hard_o,
    input logic [N_TRAPS-1:0] pending_o,
    input logic [LVL_W-1:0]   cpu_lvl_o
);
    // R2
    pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_i != '0) |=> ((pending_o & $past(fault_i)) == $past(fault_i)));

    // R3
    pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pending_o != '0) |=> ((~pending_o & $past(pending_o) & ~$past(clr_i)) == '0));

    // R4
    sel_highest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req_o |-> (pending_o[trap_vec_o] && ((pending_o >> trap_vec_o) == N_TRAPS'(1))));

    // R5
    req_outranks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req_o |-> (trap_lvl_o > cpu_lvl_o && trap_lvl_o[LVL_W-1]));

    // R6
    ack_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && trap_req_o) |=> (cpu_lvl_o == $past(trap_lvl_o)));

    // R8
    class_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req_o |-> (trap_hard_o == (trap_lvl_o >= LVL_W'(12))));
endmodule

bind trap_ctrl trap_ctrl_chk #(.N_TRAPS(N_TRAPS), .LVL_W(LVL_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fault_i     (fault_i),
    .clr_i       (clr_i),
    .ack_i       (ack_i),
    .trap_req_o  (trap_req_o),
    .trap_vec_o  (trap_vec_o),
    .trap_lvl_o  (trap_lvl_o),
    .trap_hard_o (trap_hard_o),
    .pending_o   (pending_o),
    .cpu_lvl_o   (cpu_lvl_o)
);

// File: tb/tb_trap_ctrl.sv
// Directed bench for trap_ctrl: one task per scenario, each checking itself.
module tb_trap_ctrl;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] fault_i;
    logic [7:0] clr_i;
    logic       ack_i;
    logic       lvl_we_i;
    logic [3:0] lvl_wdata_i;
    logic       trap_req_o;
    logic [2:0] trap_vec_o;
    logic [3:0] trap_lvl_o;
    logic       trap_hard_o;
    logic [7:0] pending_o;
    logic [3:0] cpu_lvl_o;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    trap_ctrl dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .fault_i     (fault_i),
        .clr_i       (clr_i),
        .ack_i       (ack_i),
        .lvl_we_i    (lvl_we_i),
        .lvl_wdata_i (lvl_wdata_i),
        .trap_req_o  (trap_req_o),
        .trap_vec_o  (trap_vec_o),
        .trap_lvl_o  (trap_lvl_o),
        .trap_hard_o (trap_hard_o),
        .pending_o   (pending_o),
        .cpu_lvl_o   (cpu_lvl_o)
    );

    task automatic chk(input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // One clock: inputs were driven at a falling edge; results read at the next.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        fault_i  = '0;
        clr_i    = '0;
        ack_i    = 1'b0;
        lvl_we_i = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1", "pending", pending_o, 0);
        chk("R1", "cpu_lvl", cpu_lvl_o, 0);
        chk("R1", "req", trap_req_o, 0);
    endtask

    task automatic t_single();
        fault_i = 8'h08;            // level 11, arithmetic
        step();
        chk("R2", "pending", pending_o, 8'h08);
        chk("R4", "vec", trap_vec_o, 3);
        chk("R4", "lvl", trap_lvl_o, 11);
        chk("R5", "req", trap_req_o, 1);
        chk("R8", "soft class", trap_hard_o, 0);
        step();
        step();
        chk("R2", "sticky", pending_o, 8'h08);
    endtask

    task automatic t_ack();
        ack_i = 1'b1;
        step();
        chk("R6", "cpu_lvl", cpu_lvl_o, 11);
        chk("R6", "req dropped", trap_req_o, 0);
        chk("R2", "pending kept", pending_o, 8'h08);
    endtask

    task automatic t_nest();
        fault_i = 8'h40;            // level 14, oscillator
        step();
        chk("R7", "nested req", trap_req_o, 1);
        chk("R7", "nested vec", trap_vec_o, 6);
        chk("R8", "hard class", trap_hard_o, 1);
        ack_i = 1'b1;
        step();
        chk("R7", "cpu_lvl", cpu_lvl_o, 14);
        fault_i = 8'h10;            // level 12, lower than current
        step();
        chk("R7", "lower no req", trap_req_o, 0);
        chk("R7", "lower pending", pending_o, 8'h58);
        ack_i = 1'b1;               // no request raised
        step();
        chk("R6", "stray ack", cpu_lvl_o, 14);
    endtask

    task automatic t_clear();
        clr_i = 8'hFF;
        step();
        chk("R3", "cleared", pending_o, 0);
        fault_i = 8'h01;
        clr_i   = 8'h01;
        step();
        chk("R3", "fault beats clear", pending_o, 8'h01);
        clr_i = 8'h01;
        step();
        chk("R3", "clear again", pending_o, 0);
    endtask

    task automatic t_level7();
        lvl_we_i    = 1'b1;
        lvl_wdata_i = 4'd7;
        step();
        chk("R9", "write 7", cpu_lvl_o, 7);
        fault_i = 8'h01;            // level 8
        step();
        chk("R5", "req at level 7", trap_req_o, 1);
        lvl_we_i    = 1'b1;
        lvl_wdata_i = 4'd8;
        step();
        chk("R5", "equal level no req", trap_req_o, 0);
        clr_i       = 8'hFF;
        lvl_we_i    = 1'b1;
        lvl_wdata_i = 4'd0;
        step();
    endtask

    task automatic t_multi();
        fault_i = 8'h38;            // levels 11, 12, 13 together
        step();
        chk("R10", "all pending", pending_o, 8'h38);
        chk("R10", "top vec", trap_vec_o, 5);
        chk("R4", "top lvl", trap_lvl_o, 13);
        ack_i       = 1'b1;
        lvl_we_i    = 1'b1;
        lvl_wdata_i = 4'd0;
        step();
        chk("R9", "ack over write", cpu_lvl_o, 13);
        chk("R10", "others stay", pending_o, 8'h38);
        clr_i       = 8'h20;
        lvl_we_i    = 1'b1;
        lvl_wdata_i = 4'd0;
        step();
        chk("R10", "next highest", trap_vec_o, 4);
        chk("R5", "req after lowering", trap_req_o, 1);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n       = 1'b0;
        fault_i     = '0;
        clr_i       = '0;
        ack_i       = 1'b0;
        lvl_we_i    = 1'b0;
        lvl_wdata_i = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_ack();
        t_nest();
        t_clear();
        t_level7();
        t_multi();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule